// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Write-Buffer Bypass

This block is a clocked single-port static memory with an 18-bit word, split into two 9-bit byte lanes. Commands are taken on the rising clock edge. A command is made of an address, a select, a global write enable and one write enable per lane. A write command carries no data in its own cycle. Its data is taken from the input bus one cycle later and parked in a one-entry write buffer. The parked word is moved into the array only when the next write command arrives. An address comparator checks every read against the parked address. On a match, the lanes that the pending write enabled are served from the buffer and the remaining lanes from the array. A read issued in the very cycle the write data arrives also sees that data.

The shared data bus is modelled as three signals: an input, an output and a drive enable. Read data is registered and appears one cycle after the read is sampled. The drive enable has three causes that switch it off. It goes low in deselected cycles and in write-data cycles. It also follows the output-enable pin at once, without waiting for a clock edge. The address width is a parameter: 18 bits gives the full 256K-word organisation, and the default is small for simulation.

A three-state control machine tracks what the previous edge started:
- IDLE: nothing driven.
- READ: registered read data is valid and may be driven.
- CAPTURE: write data is being taken from the bus and the drive is held off.

On every edge the machine moves to one of three states, whatever state it is in:
- select low: go to IDLE.
- select high with write low: go to READ.
- select high with write high: go to CAPTURE.

Reset forces IDLE and empties the buffer.

Top module: `latewrite_sram`

## Requirements
- R1: A read command (sel=1, wr_en=0 at a rising edge) puts the stored word on dq_out after that edge. dq_out then holds that value until the next read command.
- R2: Write data is taken from dq_in at the rising edge one cycle after the write command. The value on dq_in during the command cycle itself is not used.
- R3: lane_we bit 0 enables data bits 8:0 and lane_we bit 1 enables bits 17:9. A lane whose bit is 0 keeps its previous array contents.
- R4: A read whose address equals the pending write address returns the buffered data for the enabled lanes. This includes a read issued in the cycle in which that write's data arrives.
- R5: On such a buffer hit, lanes that the pending write did not enable return the array contents.
- R6: A pending write enters the array at the next write command. The earlier address then reads back its written data from the array.
- R7: A deselect cycle (sel=0) performs no read and no write, whatever wr_en is. dq_oe is 0 in the following cycle.
- R8: dq_oe is 0 whenever oe is 0. In a cycle that follows a read command, dq_oe follows oe without waiting for a clock edge.
- R9: dq_oe is 0 in the cycle after a write command, while write data is taken from the bus.
- R10: Reset (rst_n=0) empties the write buffer, discarding the pending write, and clears dq_out and dq_oe. A later read of the discarded address returns the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Word address, sampled at the edge |
| sel | input | 1 | Synchronous select, 1 = active cycle |
| wr_en | input | 1 | Global write enable, 1 = write |
| lane_we | input | LANES | Per-lane write enables |
| oe | input | 1 | Output enable, asynchronous gate on the drive |
| dq_in | input | LANES*LANE_W | Data bus, incoming side |
| dq_out | output | LANES*LANE_W | Data bus, outgoing side (registered read data) |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
Read data and its drive enable are due half a cycle after the edge that samples the read, because one register sits on the way. The drive-off result of a write or a deselect is due in the same window. The bench drives every command on a falling edge and samples on the next falling edge, which is exactly when these results are valid. Write data is driven one step after its command. The effects of a write are checked only through later reads, so the late-write capture, the commit at the next write command and the lane merge are each timed by the command order. The output-enable gate is checked a moment after oe changes in mid-cycle, with no clock edge in between.

// File: rtl/lws_pkg.sv
package lws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_CAPT = 2'd2
    } lws_state_e;
endpackage

// File: rtl/lws_ctrl.sv
module lws_ctrl
    import lws_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic wr_en,
    input  logic oe,
    output logic cmd_wr,
    output logic cmd_rd,
    output logic capt,
    output logic dq_oe
);
    lws_state_e state, state_nxt;
    logic       drive;

    always_comb begin
        if (!sel)       state_nxt = ST_IDLE;
        else if (wr_en) state_nxt = ST_CAPT;
        else            state_nxt = ST_READ;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        cmd_wr = sel && wr_en;
        cmd_rd = sel && !wr_en;
        capt   = 1'b0;
        drive  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_READ: drive = 1'b1;
            ST_CAPT: capt  = 1'b1;
            default: ;
        endcase
        dq_oe = oe && drive;
    end
endmodule

// File: rtl/lws_wbuf.sv
module lws_wbuf #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              capt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DW-1:0]     dq_in,
    input  logic [DW-1:0]     arr_word,
    output logic [LANES-1:0]  commit_lanes,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DW-1:0]     commit_data,
    output logic [DW-1:0]     rd_word
);
    logic              b_valid;
    logic [ADDR_W-1:0] b_addr;
    logic [LANES-1:0]  b_mask;
    logic [DW-1:0]     b_data;
    logic [DW-1:0]     eff_data;
    logic              hit;

    // data arriving this cycle belongs to the buffered entry
    assign eff_data     = capt ? dq_in : b_data;
    assign hit          = b_valid && (b_addr == addr);
    assign commit_lanes = (cmd_wr && b_valid) ? b_mask : '0;
    assign commit_addr  = b_addr;
    assign commit_data  = eff_data;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rd_word[l*LANE_W +: LANE_W] = (hit && b_mask[l])
            ? eff_data[l*LANE_W +: LANE_W]
            : arr_word[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_valid <= 1'b0;
            b_addr  <= '0;
            b_mask  <= '0;
            b_data  <= '0;
        end else begin
            if (cmd_wr) begin
                b_valid <= 1'b1;
                b_addr  <= addr;
                b_mask  <= lane_we;
            end
            if (capt) b_data <= dq_in;
        end
    end
endmodule

// File: rtl/lws_array.sv
module lws_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data
);
    for (genvar l = 0; l < LANES; l++) begin : g_bank
        logic [LANE_W-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_lanes[l]) cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
        end
        assign rd_data[l*LANE_W +: LANE_W] = cells[rd_addr];
    end
endmodule

// File: rtl/latewrite_sram.sv
module latewrite_sram #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_we,
    input  logic              oe,
    input  logic [DW-1:0]     dq_in,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe
);
    logic              cmd_wr, cmd_rd, capt;
    logic [LANES-1:0]  commit_lanes;
    logic [ADDR_W-1:0] commit_addr;
    logic [DW-1:0]     commit_data, arr_word, rd_word;

    lws_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .oe(oe),
        .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .capt(capt), .dq_oe(dq_oe)
    );

    lws_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .capt(capt),
        .addr(addr), .lane_we(lane_we), .dq_in(dq_in), .arr_word(arr_word),
        .commit_lanes(commit_lanes), .commit_addr(commit_addr),
        .commit_data(commit_data), .rd_word(rd_word)
    );

    lws_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .wr_lanes(commit_lanes), .wr_addr(commit_addr),
        .wr_data(commit_data), .rd_addr(addr), .rd_data(arr_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dq_out <= '0;
        else if (cmd_rd) dq_out <= rd_word;
    end
endmodule

// File: rtl/lws_chk.sv
module lws_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel,
    input logic          wr_en,
    input logic          oe,
    input logic          dq_oe,
    input logic [DW-1:0] dq_out
);
    // R9
    capture_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en) |=> !dq_oe);

    // R7
    deselect_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !dq_oe);

    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !dq_oe);

    // R8
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_en) ##1 oe |-> dq_oe);

    // R1
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !wr_en) |=> $stable(dq_out));
endmodule

bind latewrite_sram lws_chk #(.DW(LANES * LANE_W)) u_lws_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
    .oe(oe), .dq_oe(dq_oe), .dq_out(dq_out)
);

// File: tb/latewrite_sram_test.sv
module latewrite_sram_test;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;
    localparam logic [17:0] GARB = 18'h2A5A5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic        sel = 1'b0, wr_en = 1'b0, oe = 1'b1;
    logic [1:0]  lane_we = '0;
    logic [17:0] dq_in = '0;
    logic [17:0] dq_out;
    logic        dq_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [17:0] mem [DEPTH];
    bit          mb_valid = 1'b0;
    logic [AW-1:0] mb_addr = '0;
    logic [1:0]  mb_mask = '0;
    logic [17:0] mb_data = '0;
    bit          pend_use = 1'b0;
    logic [17:0] pend_data = '0;

    latewrite_sram #(.ADDR_W(AW), .LANES(2), .LANE_W(9)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel(sel), .wr_en(wr_en),
        .lane_we(lane_we), .oe(oe), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] pat(input int a, input int k);
        return 18'((a * 7919 + k * 1237 + 5) % 262144);
    endfunction

    // one command per cycle: drive at a falling edge, check at the next
    task automatic step(input logic s, input logic w, input logic [AW-1:0] a,
                        input logic [1:0] m, input logic [17:0] d, input string tag);
        logic [17:0] exp;
        bit hit;
        sel = s; wr_en = w; addr = a; lane_we = m;
        dq_in = pend_use ? pend_data : GARB;   // R2: data one cycle after command
        if (pend_use) mb_data = pend_data;
        exp = '0;
        hit = mb_valid && (mb_addr == a);
        if (s && !w) begin
            for (int l = 0; l < 2; l++)
                exp[l*9 +: 9] = (hit && mb_mask[l]) ? mb_data[l*9 +: 9] : mem[a][l*9 +: 9];
        end
        if (s && w) begin
            if (mb_valid)
                for (int l = 0; l < 2; l++)
                    if (mb_mask[l]) mem[mb_addr][l*9 +: 9] = mb_data[l*9 +: 9];
            mb_valid = 1'b1; mb_addr = a; mb_mask = m;
        end
        pend_use = s && w;
        pend_data = d;
        @(posedge clk);
        @(negedge clk);
        if (s && !w) begin
            chk(tag, dq_out, exp);
            chk({tag, "_oe"}, {17'd0, dq_oe}, {17'd0, oe});
        end else if (s) begin
            chk("R9", {17'd0, dq_oe}, 18'd0);
        end else begin
            chk("R7", {17'd0, dq_oe}, 18'd0);
        end
    endtask

    task automatic wr(input int a, input logic [1:0] m, input logic [17:0] d);
        step(1'b1, 1'b1, AW'(a), m, d, "W");
    endtask
    task automatic rd(input int a, input string tag);
        step(1'b1, 1'b0, AW'(a), 2'b00, 18'd0, tag);
    endtask
    task automatic dsel(input logic w, input int a);
        step(1'b0, w, AW'(a), 2'b11, 18'h3FFFF, "R7");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R10", {17'd0, dq_oe}, 18'd0);
        chk("R10", dq_out, 18'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // fill every word with full lanes, then read all back
        for (int a = 0; a < DEPTH; a++) wr(a, 2'b11, pat(a, 0));
        dsel(1'b0, 0);
        for (int a = 0; a < DEPTH; a++) rd(a, "R1");

        // R2: read right after write sees the late data, not command-cycle value
        wr(4, 2'b11, 18'h13579);
        rd(4, "R2");

        // R3 / R5: every lane mask on every address, read same and neighbour
        for (int a = 0; a < DEPTH; a++)
            for (int m = 0; m < 4; m++) begin
                wr(a, 2'(m), pat(a, m + 1));
                rd(a, "R5");
                rd((a + 1) % DEPTH, "R3");
            end

        // R6: second write commits the first
        wr(2, 2'b11, 18'h0BEEF);
        wr(9, 2'b01, 18'h3C3C3);
        rd(2, "R6");
        rd(9, "R4");
        wr(11, 2'b10, 18'h21212);
        rd(9, "R6");
        rd(11, "R4");
        rd(2, "R6");

        // R7: deselect with write asserted does nothing
        dsel(1'b1, 6);
        dsel(1'b1, 6);
        rd(6, "R7");
        wr(1, 2'b11, 18'h11111);
        rd(6, "R7");

        // R8: output enable gates the drive without a clock edge
        rd(3, "R1");
        #2 oe = 1'b0;
        #1 chk("R8", {17'd0, dq_oe}, 18'd0);
        oe = 1'b1;
        #1 chk("R8", {17'd0, dq_oe}, 18'd1);
        oe = 1'b0;
        rd(5, "R8");
        oe = 1'b1;
        @(negedge clk);

        // R10: reset discards a pending write
        wr(7, 2'b11, 18'h2F0F0);
        dsel(1'b0, 0);
        rst_n = 1'b0;
        mb_valid = 1'b0; pend_use = 1'b0;
        sel = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        chk("R10", {17'd0, dq_oe}, 18'd0);
        chk("R10", dq_out, 18'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(7, "R10");
        wr(7, 2'b01, 18'h00077);
        wr(8, 2'b11, 18'h00088);
        dsel(1'b0, 0);
        rd(7, "R10");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule